// File: doc/BRIEF.md
# Edge-Capturing Interrupt Aggregator

This block gathers up to nine interrupt request lines from other blocks and merges them into one interrupt towards the host bridge. All request lines are synchronous to the block clock. A low-to-high transition on a line is remembered in a source register, one bit per line. The host reads that register through a plain 32-bit register port, and the read clears it. A second register, an enable mask with the same bit layout, decides which captured edges may raise the outgoing interrupt. The outgoing interrupt is a one-cycle pulse, not a level.

In the default build, the source bits are assigned by bit position, counting from bit 0: DMA done, carrier over-temperature, mezzanine over-temperature, input overload, trigger, shot complete, identification-bus transfer done, clock-bus transfer done, and converter-configuration transfer done. Bit 31 of the source register is a debug flag. It records that some line rose again while its bit was still waiting to be read.

The register port uses a word address (`bus_addr_i`). Word offset 0 is the source register and is read-only. Word offset 1 is the enable register and can be read and written. Only full 32-bit accesses exist. Read data is registered and appears on `bus_rdata_o` one clock after the read strobe. It then holds until the next read.

Top module: `irq_edge_aggregator`

## Requirements
- R1: After synchronous reset, the source register, bit 31 and the enable register all read as zero, and `irq_o` is low.
- R2: A line that is low in one cycle and high in the next sets source bit i, where i is the line's index (0 to 8). A line that simply stays high sets nothing more.
- R3: A read at offset 0 returns the source bits and bit 31 as they were before the read, then clears all of them. The cleared state shows on the next read.
- R4: If an edge arrives in the same cycle as a clearing read, that read does not return the edge. The bit is set after the read, and this coincidence does not set bit 31.
- R5: The enable register at offset 1 stores write-data bits 8:0 and reads back only those bits. Writes to offset 0 have no effect.
- R6: A captured edge on a line whose enable bit is 1 drives `irq_o` high in the cycle after the clock edge that samples it. An edge on a disabled line is still captured but raises no pulse.
- R7: `irq_o` is never high for two cycles in a row. Enabled edges that land in the same cycle produce a single pulse. An enabled edge that arrives while `irq_o` is high produces a further pulse two cycles later.
- R8: Bit 31 of the source register is set when a line rises while its source bit is already set and no clearing read happens in that cycle. The flag stays set until a read at offset 0. It ignores the enable mask and never raises `irq_o` by itself.
- R9: Bits 30:9 of every read word are zero, and reads at any offset other than 0 or 1 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | N_SRC (9) | Interrupt request lines, synchronous to clk |
| bus_addr_i | input | ADDR_W (4) | Word address of the register access |
| bus_wr_i | input | 1 | Write strobe, one cycle per access |
| bus_rd_i | input | 1 | Read strobe, one cycle per access |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data, valid the cycle after the read strobe |
| irq_o | output | 1 | One-cycle interrupt pulse to the host bridge |

## Verification
The hardest corner is an edge that lands in the same cycle as a clearing read. A design that lets the clear win loses that interrupt for good. A design that treats the coincidence as a repeat flags bit 31 when it should not. Back-to-back edges on different enabled lines are driven one cycle apart. A naive edge-to-pulse register would either stretch `irq_o` into a two-cycle level or drop the second interrupt. The bench also raises the same masked line twice. This catches a bit 31 that is wrongly masked, is never set, or raises a pulse on its own. Finally, a line held high across a clearing read checks that a level is not mistaken for a fresh edge.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

  localparam int unsigned BUS_W = 32;

  typedef logic [BUS_W-1:0] bus_word_t;

  // Word with the lowest n bits set.
  function automatic bus_word_t low_mask(input int unsigned n);
    bus_word_t m;
    m = '0;
    for (int unsigned i = 0; i < BUS_W; i++) begin
      if (i < n) m[i] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/irq_edge_detect.sv
// Per-line rising-edge detector on synchronous request lines.
module irq_edge_detect #(
  parameter int unsigned N_SRC = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] req_i,
  output logic [N_SRC-1:0] edge_o
);

  logic [N_SRC-1:0] prev_q;

  for (genvar g = 0; g < N_SRC; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) prev_q[g] <= 1'b0;
      else     prev_q[g] <= req_i[g];
    end
    assign edge_o[g] = req_i[g] & ~prev_q[g];
  end

endmodule

// File: rtl/irq_src_bank.sv
// Clear-on-read source bits plus the sticky "rose again" flag.
module irq_src_bank #(
  parameter int unsigned N_SRC = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] edge_i,
  input  logic             clr_i,
  output logic [N_SRC-1:0] src_o,
  output logic             again_o
);

  logic [N_SRC-1:0] kept;
  logic             repeat_hit;

  // The clear acts on the old contents only; edges of this cycle are ORed
  // in afterwards so a coincident read never swallows them.
  assign kept       = clr_i ? '0 : src_o;
  assign repeat_hit = |(edge_i & kept);

  always_ff @(posedge clk) begin
    if (rst) begin
      src_o   <= '0;
      again_o <= 1'b0;
    end else begin
      src_o   <= kept | edge_i;
      again_o <= (again_o & ~clr_i) | repeat_hit;
    end
  end

endmodule

// File: rtl/irq_pulse_gen.sv
// Turns enabled edges into one-cycle pulses with a one-deep pending slot.
module irq_pulse_gen #(
  parameter int unsigned N_SRC = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] edge_i,
  input  logic [N_SRC-1:0] en_i,
  output logic             irq_o
);

  logic hit;
  logic pend_q;
  logic want;

  assign hit  = |(edge_i & en_i);
  assign want = hit | pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      irq_o  <= want & ~irq_o;
      pend_q <= want & irq_o;
    end
  end

endmodule

// File: rtl/irq_edge_aggregator.sv
module irq_edge_aggregator
  import irq_agg_pkg::*;
#(
  parameter int unsigned N_SRC     = 9,
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned SRC_OFS   = 0,
  parameter int unsigned EN_OFS    = 1,
  parameter int unsigned AGAIN_BIT = 31
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N_SRC-1:0]    req_i,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic                bus_wr_i,
  input  logic                bus_rd_i,
  input  logic [BUS_W-1:0]    bus_wdata_i,
  output logic [BUS_W-1:0]    bus_rdata_o,
  output logic                irq_o
);

  localparam bus_word_t         EN_MASK = low_mask(N_SRC);
  localparam logic [ADDR_W-1:0] SRC_A   = ADDR_W'(SRC_OFS);
  localparam logic [ADDR_W-1:0] EN_A    = ADDR_W'(EN_OFS);

  logic [N_SRC-1:0] edges;
  logic [N_SRC-1:0] src_q;
  logic             again_q;
  bus_word_t        en_q;
  logic             src_clr;
  bus_word_t        src_word;

  assign src_clr = bus_rd_i & (bus_addr_i == SRC_A);

  irq_edge_detect #(.N_SRC(N_SRC)) u_edge (
    .clk    (clk),
    .rst    (rst),
    .req_i  (req_i),
    .edge_o (edges)
  );

  irq_src_bank #(.N_SRC(N_SRC)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .edge_i  (edges),
    .clr_i   (src_clr),
    .src_o   (src_q),
    .again_o (again_q)
  );

  irq_pulse_gen #(.N_SRC(N_SRC)) u_pulse (
    .clk    (clk),
    .rst    (rst),
    .edge_i (edges),
    .en_i   (en_q[N_SRC-1:0]),
    .irq_o  (irq_o)
  );

  always_ff @(posedge clk) begin
    if (rst)                                   en_q <= '0;
    else if (bus_wr_i && bus_addr_i == EN_A)   en_q <= bus_wdata_i & EN_MASK;
  end

  always_comb begin
    src_word             = '0;
    src_word[N_SRC-1:0]  = src_q;
    src_word[AGAIN_BIT]  = again_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata_o <= '0;
    end else if (bus_rd_i) begin
      if (bus_addr_i == SRC_A)     bus_rdata_o <= src_word;
      else if (bus_addr_i == EN_A) bus_rdata_o <= en_q;
      else                         bus_rdata_o <= '0;
    end
  end

endmodule

// File: rtl/irq_edge_aggregator_chk.sv
module irq_edge_aggregator_chk #(
  parameter int unsigned N_SRC     = 9,
  parameter int unsigned AGAIN_BIT = 31
) (
  input logic             clk,
  input logic             rst,
  input logic [N_SRC-1:0] req_i,
  input logic             clr,
  input logic [N_SRC-1:0] en_q,
  input logic [N_SRC-1:0] src_q,
  input logic             again_q,
  input logic [31:0]      bus_rdata_o,
  input logic             irq_o
);

  localparam logic [31:0] RSVD =
    ~((32'h1 << N_SRC) - 32'h1) & ~(32'h1 << AGAIN_BIT);

  logic [N_SRC-1:0] req_d;
  logic [N_SRC-1:0] edg;

  always_ff @(posedge clk) begin
    if (rst) req_d <= '0;
    else     req_d <= req_i;
  end
  assign edg = req_i & ~req_d;

  // R7
  pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o |=> !irq_o);

  // R6
  enabled_edge_irq_chk: assert property (@(posedge clk) disable iff (rst)
    ((|(edg & en_q)) && !irq_o) |=> irq_o);

  // R3
  clear_read_chk: assert property (@(posedge clk) disable iff (rst)
    (clr && edg == '0) |=> (src_q == '0 && !again_q));

  // R4
  keep_coincident_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> ((src_q & $past(edg)) == $past(edg)));

  // R2
  edge_sets_chk: assert property (@(posedge clk) disable iff (rst)
    (|edg) |=> ((src_q & $past(edg)) == $past(edg)));

  // R8
  again_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (again_q && !clr) |=> again_q);

  // R9
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rdata_o & RSVD) == 32'h0);

endmodule

bind irq_edge_aggregator irq_edge_aggregator_chk #(
  .N_SRC(N_SRC), .AGAIN_BIT(AGAIN_BIT)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_i       (req_i),
  .clr         (src_clr),
  .en_q        (en_q[N_SRC-1:0]),
  .src_q       (src_q),
  .again_q     (again_q),
  .bus_rdata_o (bus_rdata_o),
  .irq_o       (irq_o)
);

// File: tb/tb_irq_edge_aggregator.sv
module tb_irq_edge_aggregator;

  logic        clk = 1'b0;
  logic        rst;
  logic [8:0]  req_i;
  logic [3:0]  bus_addr_i;
  logic        bus_wr_i;
  logic        bus_rd_i;
  logic [31:0] bus_wdata_i;
  logic [31:0] bus_rdata_o;
  logic        irq_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  irq_edge_aggregator dut (
    .clk(clk), .rst(rst), .req_i(req_i), .bus_addr_i(bus_addr_i),
    .bus_wr_i(bus_wr_i), .bus_rd_i(bus_rd_i), .bus_wdata_i(bus_wdata_i),
    .bus_rdata_o(bus_rdata_o), .irq_o(irq_o)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr_i = a;
    bus_rd_i   = 1'b1;
    tick();
    bus_rd_i   = 1'b0;
    d          = bus_rdata_o;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] v);
    bus_addr_i  = a;
    bus_wdata_i = v;
    bus_wr_i    = 1'b1;
    tick();
    bus_wr_i    = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 irq after reset", {31'h0, irq_o}, 32'h0);
    rd(4'd0, d); chk("R1 source after reset", d, 32'h0);
    rd(4'd1, d); chk("R1 enable after reset", d, 32'h0);
  endtask

  task automatic t_capture();
    logic [31:0] d;
    req_i = 9'h005; tick();
    chk("R6 masked edge no pulse", {31'h0, irq_o}, 32'h0);
    tick(); tick();
    rd(4'd0, d); chk("R2 edges captured", d, 32'h0000_0005);
    rd(4'd0, d); chk("R3 cleared, held level not re-captured", d, 32'h0);
    req_i = 9'h000; tick();
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(4'd1, 32'hFFFF_FFFF);
    rd(4'd1, d); chk("R5 enable stores low 9 bits", d, 32'h0000_01FF);
    wr(4'd0, 32'hFFFF_FFFF);
    rd(4'd0, d); chk("R5 write to source ignored", d, 32'h0);
    rd(4'd7, d); chk("R9 unmapped offset reads zero", d, 32'h0);
    wr(4'd1, 32'h0000_01FB);
    rd(4'd1, d); chk("R5 enable readback", d, 32'h0000_01FB);
  endtask

  task automatic t_pulse();
    logic [31:0] d;
    req_i = 9'h001; tick();
    chk("R6 enabled edge pulses", {31'h0, irq_o}, 32'h1);
    tick();
    chk("R7 pulse is one cycle", {31'h0, irq_o}, 32'h0);
    req_i = 9'h000;
    rd(4'd0, d); chk("R2 bit0 captured", d, 32'h0000_0001);
  endtask

  task automatic t_multi();
    logic [31:0] d;
    req_i = 9'h00B; tick();
    chk("R7 simultaneous edges pulse", {31'h0, irq_o}, 32'h1);
    tick();
    chk("R7 simultaneous edges single pulse", {31'h0, irq_o}, 32'h0);
    req_i = 9'h000;
    rd(4'd0, d); chk("R2 several bits captured", d, 32'h0000_000B);
  endtask

  task automatic t_back_to_back();
    logic [31:0] d;
    req_i = 9'h001; tick();
    chk("R6 first pulse", {31'h0, irq_o}, 32'h1);
    req_i = 9'h003; tick();
    chk("R7 gap after first pulse", {31'h0, irq_o}, 32'h0);
    tick();
    chk("R7 deferred second pulse", {31'h0, irq_o}, 32'h1);
    tick();
    chk("R7 deferred pulse ends", {31'h0, irq_o}, 32'h0);
    req_i = 9'h000;
    rd(4'd0, d); chk("R2 both lines captured", d, 32'h0000_0003);
  endtask

  task automatic t_coincide();
    logic [31:0] d;
    req_i = 9'h010;
    rd(4'd0, d); chk("R4 coincident read returns old value", d, 32'h0);
    req_i = 9'h000;
    rd(4'd0, d); chk("R4 coincident edge kept", d, 32'h0000_0010);
    req_i = 9'h010; tick();
    req_i = 9'h000; tick();
    req_i = 9'h010;
    rd(4'd0, d); chk("R4 read with edge on set bit", d, 32'h0000_0010);
    req_i = 9'h000;
    rd(4'd0, d); chk("R4 no repeat flag from coincidence", d, 32'h0000_0010);
  endtask

  task automatic t_again();
    logic [31:0] d;
    req_i = 9'h004; tick();
    chk("R6 masked line no pulse", {31'h0, irq_o}, 32'h0);
    req_i = 9'h000; tick();
    req_i = 9'h004; tick();
    chk("R8 repeat flag raises no pulse", {31'h0, irq_o}, 32'h0);
    req_i = 9'h000; tick();
    chk("R8 repeat flag raises no pulse later", {31'h0, irq_o}, 32'h0);
    rd(4'd0, d); chk("R8 repeat flag set on masked line", d, 32'h8000_0004);
    rd(4'd0, d); chk("R3 repeat flag cleared by read", d, 32'h0);
    req_i = 9'h020; tick();
    req_i = 9'h000; tick();
    req_i = 9'h020; tick();
    req_i = 9'h000; tick();
    rd(4'd0, d); chk("R8 repeat flag on enabled line", d, 32'h8000_0020);
  endtask

  initial begin
    rst = 1'b1; req_i = '0; bus_addr_i = '0; bus_wr_i = 1'b0;
    bus_rd_i = 1'b0; bus_wdata_i = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    tick();
    t_reset();
    t_capture();
    t_regs();
    t_pulse();
    t_multi();
    t_back_to_back();
    t_coincide();
    t_again();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

endmodule